// File: doc/BRIEF.md
# Pixel-Doubled Bitmap Scanout Engine

This block produces a 640×480 progressive raster at 60 Hz on a 25 MHz pixel clock from a 320×240 bitmap held in an external asynchronous SRAM. Each stored byte is one pixel coded with three red, three green and two blue bits. The block generates its own horizontal and vertical timing. It addresses the SRAM in step with the beam and shows every stored pixel as a 2×2 block of output pixels. Each colour channel is widened to the output colour width.

It runs in the pixel clock domain and reads the SRAM on its own schedule. A read is started on the even column of each pixel pair, and the byte is captured at the next clock edge. The captured byte then serves both output columns, so the SRAM sees one access every two pixel clocks. During horizontal and vertical blanking no reads are made and the colour outputs are driven to zero.

Top module: `fb_scanout`

## Requirements
- R1: A horizontal position counter runs from 0 to H_ACTIVE+H_FP+H_SYNC+H_BP-1 and then wraps to 0. A vertical line counter advances at each horizontal wrap and wraps after V_ACTIVE+V_FP+V_SYNC+V_BP lines. Both counters are 0 in the first cycle after reset is released.
- R2: `vid_de` is high exactly when the position (h, v) sampled three cycles earlier has h < H_ACTIVE and v < V_ACTIVE.
- R3: `vid_hsync` is high (active-high) for the H_SYNC positions starting at h = H_ACTIVE+H_FP. `vid_vsync` is high for the V_SYNC lines starting at v = V_ACTIVE+V_FP. Both carry the same three-cycle latency as `vid_de`.
- R4: `sram_oe_n` (active-low read strobe) is low for exactly one cycle, in the cycle after a position with an even h inside the active area. It stays high at every other time, including throughout blanking.
- R5: During a read, `sram_addr` equals (v >> 1) × (H_ACTIVE/2) + (h >> 1) for the position that started the read.
- R6: Every stored pixel is shown on output columns 2c and 2c+1 of output lines 2r and 2r+1.
- R7: Bits [7:5] of a stored byte are red, [4:2] are green and [1:0] are blue. Each channel is widened to OUT_W bits by repeating its bit pattern, MSB first, so that for OUT_W = 8 red r becomes {r, r, r[2:1]} and blue b becomes {b, b, b, b}.
- R8: `vid_r`, `vid_g` and `vid_b` are all zero whenever `vid_de` is low.
- R9: `sram_data` is captured only at the clock edge that ends a read cycle. Values on `sram_data` while `sram_oe_n` is high never reach the colour outputs.
- R10: While `rst_n` is low at a clock edge, the block sets every output to zero, with `sram_oe_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sram_addr | output | ADDR_W | SRAM word address, with ADDR_W = clog2(H_ACTIVE/2 × V_ACTIVE/2) |
| sram_oe_n | output | 1 | SRAM read strobe, active low |
| sram_data | input | 8 | SRAM read data, R3G3B2 |
| vid_de | output | 1 | Active video |
| vid_hsync | output | 1 | Horizontal sync, active high |
| vid_vsync | output | 1 | Vertical sync, active high |
| vid_r | output | OUT_W | Red channel |
| vid_g | output | OUT_W | Green channel |
| vid_b | output | OUT_W | Blue channel |

## Verification
The SRAM strobe and address for a beam position are due one cycle after the counters hold that position. The matching video enable, syncs and colour are due three cycles after it. The bench steps its own beam position once per clock and works out the expected SRAM access and pixel from a behavioural SRAM array. It pushes these into queues that start with one and three reset-valued entries, so each comparison at the falling edge pops exactly the entry that has come due. The SRAM model drives a fixed junk byte whenever the strobe is idle, so any capture outside a read cycle shows up in the colour checks.

// File: rtl/fbs_pkg.sv
// Package: types shared by the scanout pipeline stages.
package fbs_pkg;

    // Beam control flags carried alongside each pipeline stage.
    typedef struct packed {
        logic de;
        logic hs;
        logic vs;
    } fbs_ctl_t;

    localparam int PIX_W = 8;
    localparam int RED_W = 3;
    localparam int GRN_W = 3;
    localparam int BLU_W = 2;

endpackage

// File: rtl/fbs_timing.sv
// Raster timing generator.
// Counts pixel positions and lines of a progressive raster and derives the
// active-area, sync flags and framebuffer coordinates (output coordinate / 2).
// Assumes all porch/sync parameters are >= 1 and active sizes are even.
module fbs_timing
    import fbs_pkg::*;
#(
    parameter int H_ACTIVE = 640,
    parameter int H_FP     = 16,
    parameter int H_SYNC   = 96,
    parameter int H_BP     = 48,
    parameter int V_ACTIVE = 480,
    parameter int V_FP     = 10,
    parameter int V_SYNC   = 2,
    parameter int V_BP     = 33,
    parameter int HW       = 10,
    parameter int VW       = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [HW-2:0] col,
    output logic          even,
    output logic [VW-2:0] row,
    output fbs_ctl_t      ctl
);
    localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP;
    localparam int V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP;
    localparam logic [HW-1:0] H_LAST   = HW'(H_TOTAL - 1);
    localparam logic [VW-1:0] V_LAST   = VW'(V_TOTAL - 1);
    localparam logic [HW-1:0] H_ACT    = HW'(H_ACTIVE);
    localparam logic [VW-1:0] V_ACT    = VW'(V_ACTIVE);
    localparam logic [HW-1:0] HS_BEGIN = HW'(H_ACTIVE + H_FP);
    localparam logic [HW-1:0] HS_END   = HW'(H_ACTIVE + H_FP + H_SYNC);
    localparam logic [VW-1:0] VS_BEGIN = VW'(V_ACTIVE + V_FP);
    localparam logic [VW-1:0] VS_END   = VW'(V_ACTIVE + V_FP + V_SYNC);

    logic [HW-1:0] hpos;
    logic [VW-1:0] vpos;

    // Advance the beam position, wrapping at line and frame ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hpos <= '0;
            vpos <= '0;
        end else if (hpos == H_LAST) begin
            hpos <= '0;
            vpos <= (vpos == V_LAST) ? '0 : vpos + 1'b1;
        end else begin
            hpos <= hpos + 1'b1;
        end
    end

    // Decode flags and framebuffer coordinates from the beam position.
    always_comb begin
        ctl.de = (hpos < H_ACT) && (vpos < V_ACT);
        ctl.hs = (hpos >= HS_BEGIN) && (hpos < HS_END);
        ctl.vs = (vpos >= VS_BEGIN) && (vpos < VS_END);
        col    = hpos[HW-1:1];
        even   = ~hpos[0];
        row    = vpos[VW-1:1];
    end

endmodule

// File: rtl/fbs_fetch.sv
// SRAM read sequencer.
// Issues one registered read per pixel pair (even active column) and latches
// the returned byte at the following edge; flags are delayed to match.
// Assumes the asynchronous SRAM returns data within one clock of the strobe.
module fbs_fetch
    import fbs_pkg::*;
#(
    parameter int CW     = 9,
    parameter int RW     = 9,
    parameter int FB_W   = 320,
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CW-1:0]     col,
    input  logic              even,
    input  logic [RW-1:0]     row,
    input  fbs_ctl_t          ctl_in,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_oe_n,
    input  logic [PIX_W-1:0]  sram_data,
    output logic [PIX_W-1:0]  pix,
    output fbs_ctl_t          ctl_out
);
    localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(FB_W);

    logic [ADDR_W-1:0] addr_next;
    logic              rd_start;
    fbs_ctl_t          ctl_mid;

    // Linear address of the framebuffer pixel under the beam.
    always_comb begin
        addr_next = ADDR_W'(row) * STRIDE + ADDR_W'(col);
        rd_start  = ctl_in.de && even;
    end

    // Drive the SRAM strobe and address for one cycle per pixel pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sram_oe_n <= 1'b1;
            sram_addr <= '0;
            ctl_mid   <= '0;
        end else begin
            sram_oe_n <= ~rd_start;
            if (rd_start) sram_addr <= addr_next;
            ctl_mid   <= ctl_in;
        end
    end

    // Capture read data only at the end of a read cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix     <= '0;
            ctl_out <= '0;
        end else begin
            if (!sram_oe_n) pix <= sram_data;
            ctl_out <= ctl_mid;
        end
    end

endmodule

// File: rtl/fbs_widen.sv
// Colour channel widener.
// Replicates an IN_W-bit channel MSB-first until OUT_W bits are filled,
// so full scale maps to full scale. Assumes OUT_W >= IN_W.
module fbs_widen #(
    parameter int IN_W  = 3,
    parameter int OUT_W = 8
) (
    input  logic [IN_W-1:0]  narrow,
    output logic [OUT_W-1:0] wide
);
    // Each output bit copies the input bit at the same place in the pattern.
    for (genvar i = 0; i < OUT_W; i++) begin : g_rep
        assign wide[OUT_W-1-i] = narrow[IN_W-1-(i % IN_W)];
    end

endmodule

// File: rtl/fb_scanout.sv
// Pixel-doubled bitmap scanout top.
// Timing -> SRAM fetch -> colour widening -> registered video outputs.
// Video outputs lag the beam counters by three clocks; SRAM strobe by one.
// Assumes one pixel clock domain and synchronous active-low reset.
module fb_scanout
    import fbs_pkg::*;
#(
    parameter int H_ACTIVE = 640,
    parameter int H_FP     = 16,
    parameter int H_SYNC   = 96,
    parameter int H_BP     = 48,
    parameter int V_ACTIVE = 480,
    parameter int V_FP     = 10,
    parameter int V_SYNC   = 2,
    parameter int V_BP     = 33,
    parameter int OUT_W    = 8,
    parameter int FB_W     = H_ACTIVE / 2,
    parameter int FB_H     = V_ACTIVE / 2,
    parameter int ADDR_W   = $clog2(FB_W * FB_H)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_oe_n,
    input  logic [7:0]        sram_data,
    output logic              vid_de,
    output logic              vid_hsync,
    output logic              vid_vsync,
    output logic [OUT_W-1:0]  vid_r,
    output logic [OUT_W-1:0]  vid_g,
    output logic [OUT_W-1:0]  vid_b
);
    localparam int HW = $clog2(H_ACTIVE + H_FP + H_SYNC + H_BP);
    localparam int VW = $clog2(V_ACTIVE + V_FP + V_SYNC + V_BP);

    logic [HW-2:0]    col;
    logic [VW-2:0]    row;
    logic             even;
    fbs_ctl_t         ctl0;
    fbs_ctl_t         ctl2;
    logic [PIX_W-1:0] pix;
    logic [OUT_W-1:0] r_w, g_w, b_w;

    fbs_timing #(
        .H_ACTIVE(H_ACTIVE), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
        .V_ACTIVE(V_ACTIVE), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
        .HW(HW), .VW(VW)
    ) timing_i (
        .clk(clk), .rst_n(rst_n),
        .col(col), .even(even), .row(row), .ctl(ctl0)
    );

    fbs_fetch #(
        .CW(HW - 1), .RW(VW - 1), .FB_W(FB_W), .ADDR_W(ADDR_W)
    ) fetch_i (
        .clk(clk), .rst_n(rst_n),
        .col(col), .even(even), .row(row), .ctl_in(ctl0),
        .sram_addr(sram_addr), .sram_oe_n(sram_oe_n), .sram_data(sram_data),
        .pix(pix), .ctl_out(ctl2)
    );

    fbs_widen #(.IN_W(RED_W), .OUT_W(OUT_W)) widen_r_i (
        .narrow(pix[PIX_W-1 -: RED_W]), .wide(r_w));
    fbs_widen #(.IN_W(GRN_W), .OUT_W(OUT_W)) widen_g_i (
        .narrow(pix[BLU_W +: GRN_W]), .wide(g_w));
    fbs_widen #(.IN_W(BLU_W), .OUT_W(OUT_W)) widen_b_i (
        .narrow(pix[BLU_W-1:0]), .wide(b_w));

    // Register the video outputs, forcing black outside the active area.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vid_de    <= 1'b0;
            vid_hsync <= 1'b0;
            vid_vsync <= 1'b0;
            vid_r     <= '0;
            vid_g     <= '0;
            vid_b     <= '0;
        end else begin
            vid_de    <= ctl2.de;
            vid_hsync <= ctl2.hs;
            vid_vsync <= ctl2.vs;
            vid_r     <= ctl2.de ? r_w : '0;
            vid_g     <= ctl2.de ? g_w : '0;
            vid_b     <= ctl2.de ? b_w : '0;
        end
    end

endmodule

// File: rtl/fb_scanout_chk.sv
// Checker for fb_scanout: port-level temporal properties, bound to the top.
module fb_scanout_chk #(
    parameter int ADDR_W    = 17,
    parameter int OUT_W     = 8,
    parameter int FB_PIXELS = 76800
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              sram_oe_n,
    input logic              vid_de,
    input logic              vid_hsync,
    input logic              vid_vsync,
    input logic [OUT_W-1:0]  vid_r,
    input logic [OUT_W-1:0]  vid_g,
    input logic [OUT_W-1:0]  vid_b
);
    // A read strobe is always followed by an idle cycle.
    assert_read_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |=> sram_oe_n);

    // Read addresses stay inside the framebuffer.
    assert_addr_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |-> (32'(sram_addr) < FB_PIXELS));

    // Black outside the active area.
    assert_blank_black_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !vid_de |-> (vid_r == '0 && vid_g == '0 && vid_b == '0));

    // Sync pulses fall in blanking only.
    assert_sync_in_blank_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_hsync || vid_vsync) |-> !vid_de);

    // Active runs come in whole pixel pairs, so never a single cycle.
    assert_de_pairs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vid_de) |=> vid_de);

endmodule

bind fb_scanout fb_scanout_chk #(
    .ADDR_W(ADDR_W), .OUT_W(OUT_W), .FB_PIXELS(FB_W * FB_H)
) chk_i (
    .clk(clk), .rst_n(rst_n), .sram_addr(sram_addr), .sram_oe_n(sram_oe_n),
    .vid_de(vid_de), .vid_hsync(vid_hsync), .vid_vsync(vid_vsync),
    .vid_r(vid_r), .vid_g(vid_g), .vid_b(vid_b)
);

// File: tb/fb_scanout_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural beam/SRAM model compared against the DUT every clock.
module fb_scanout_tb_top;
    localparam int HA = 16, HF = 2, HS = 3, HB = 3;
    localparam int VA = 8,  VF = 1, VS = 2, VB = 1;
    localparam int HT = HA + HF + HS + HB;
    localparam int VT = VA + VF + VS + VB;
    localparam int FBW = HA / 2;
    localparam int FBH = VA / 2;
    localparam int AW = $clog2(FBW * FBH);
    localparam int FRAMES = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] sram_addr;
    logic          sram_oe_n;
    logic [7:0]    sram_data;
    logic          vid_de, vid_hsync, vid_vsync;
    logic [7:0]    vid_r, vid_g, vid_b;

    logic [7:0] mem [FBW*FBH];

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    // SRAM model: data only while strobed, junk otherwise (exposes R9 errors).
    assign sram_data = !sram_oe_n ? mem[sram_addr] : 8'hA5;

    fb_scanout #(
        .H_ACTIVE(HA), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
        .V_ACTIVE(VA), .V_FP(VF), .V_SYNC(VS), .V_BP(VB), .OUT_W(8)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .sram_addr(sram_addr), .sram_oe_n(sram_oe_n),
        .sram_data(sram_data), .vid_de(vid_de), .vid_hsync(vid_hsync),
        .vid_vsync(vid_vsync), .vid_r(vid_r), .vid_g(vid_g), .vid_b(vid_b)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic load_pattern(input int p);
        for (int i = 0; i < FBW * FBH; i++) begin
            case (p)
                0: mem[i] = 8'(i * 7 + 1);
                1: mem[i] = (i % 2 == 0) ? 8'hFF : 8'h00;
                2: mem[i] = (i % 3 == 0) ? 8'hE0 : ((i % 3 == 1) ? 8'h1C : 8'h03);
                default: mem[i] = 8'((i * 37 + p * 91) ^ (i << 3));
            endcase
        end
    endtask

    function automatic int widen3(input int c);
        return (c << 5) | (c << 2) | (c >> 1);
    endfunction

    // Expected video word {de, hs, vs, r, g, b} for one beam position.
    function automatic logic [26:0] expect_vid(input int h, input int v);
        logic de, hs, vs;
        int p, r, g, b;
        de = (h < HA) && (v < VA);
        hs = (h >= HA + HF) && (h < HA + HF + HS);
        vs = (v >= VA + VF) && (v < VA + VF + VS);
        r = 0; g = 0; b = 0;
        if (de) begin
            p = int'(mem[(v / 2) * FBW + (h / 2)]);
            r = widen3((p >> 5) & 7);
            g = widen3((p >> 2) & 7);
            b = (p & 3) * 85;
        end
        return {de, hs, vs, 8'(r), 8'(g), 8'(b)};
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Watchdog: an overrun counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [26:0] vid_q[$];
        logic [AW:0] rd_q[$];
        logic [26:0] e;
        logic [AW:0] er;
        int h, v, pat;
        pat = 0;
        load_pattern(pat);
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R10: outputs in reset.
        check(vid_de == 0 && vid_hsync == 0 && vid_vsync == 0, "R10 flags", {vid_de, vid_hsync, vid_vsync}, 0);
        check(vid_r == 0 && vid_g == 0 && vid_b == 0, "R10 colour", {vid_r, vid_g, vid_b}, 0);
        check(sram_oe_n == 1 && sram_addr == 0, "R10 sram", {sram_oe_n, sram_addr}, 1 << AW);
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) vid_q.push_back('0);
        rd_q.push_back({1'b1, {AW{1'b0}}});
        h = 0; v = 0;
        for (int n = 0; n < FRAMES * HT * VT + 4; n++) begin
            vid_q.push_back(expect_vid(h, v));
            rd_q.push_back({!((h < HA) && (v < VA) && (h % 2 == 0)),
                            AW'((v / 2) * FBW + (h / 2))});
            e = vid_q.pop_front();
            er = rd_q.pop_front();
            // R1 R2: enable follows the wrapping counters with 3-cycle latency.
            check(vid_de == e[26], "R1 R2 de", vid_de, e[26]);
            // R1 R3: sync pulses.
            check({vid_hsync, vid_vsync} == e[25:24], "R1 R3 sync", {vid_hsync, vid_vsync}, e[25:24]);
            // R5 R6 R7 R8 R9: pixel doubling, widening, black blanking.
            check({vid_r, vid_g, vid_b} == e[23:0], "R5 R6 R7 R8 R9 colour", {vid_r, vid_g, vid_b}, e[23:0]);
            // R4: strobe once per pixel pair, never in blanking.
            check(sram_oe_n == er[AW], "R4 strobe", sram_oe_n, er[AW]);
            // R5: address of the pixel under the beam.
            if (!er[AW]) check(sram_addr == er[AW-1:0], "R5 addr", sram_addr, er[AW-1:0]);
            h++;
            if (h == HT) begin
                h = 0;
                v = (v == VT - 1) ? 0 : v + 1;
            end
            if (h == 0 && v == VA + 1) begin
                pat++;
                load_pattern(pat);
            end
            @(negedge clk);
        end
        finish_run();
    end

endmodule